// File: doc/BRIEF.md
# Three-Way LRU Address Translation Buffer

This block translates 8-bit byte addresses of a small paged virtual space into 7-bit physical addresses. Pages and frames are 16 bytes, so the upper four address bits select a virtual page and the lower four bits pass through unchanged. The buffer keeps three recent page-to-frame translations in a fully associative store. Any of the three can hold any page. A lookup that finds its page answers in the cycle it is accepted.

When a lookup misses, the block walks a one-level page table itself. The table sits in a fixed physical frame, and the block reads it through a simple read port. A valid entry is written over the least recently used translation and returned as the response. An invalid entry is returned as a page fault, and nothing is installed. Choosing a frame for a faulting page and loading that page are left to the surrounding system.

A preload port lets the environment seed translations before lookups begin. The block also keeps running counts of lookups and hits, so the hit rate of a reference stream can be read from the outputs.

Top module: `xlat_buffer`

## Requirements
- R1: The physical address of a translation is the 3-bit frame number placed above the 4-bit page offset, and the offset is copied from bits 3:0 of the virtual address.
- R2: A lookup whose page is held is answered in the cycle it is accepted, with `rsp_valid` and `rsp_hit` high, and no page-table read is issued.
- R3: A lookup that misses issues exactly one page-table read. That read lasts one cycle and targets physical address 0x70 plus the virtual page number (frame 7, with the page number as the byte index).
- R4: A page-table entry is one byte. Bit 7 is the valid flag and bits 2:0 are the frame number; bits 6:3 are ignored. For a valid entry, the response arrives in the cycle `pt_rd_valid` is high, with `rsp_hit` low and the new translation.
- R5: An invalid page-table entry produces a response with `rsp_fault` high and `rsp_hit` low, and the page is not installed. A repeated lookup of that page misses and reads the table again.
- R6: A refill replaces the least recently used of the three entries. Hits, refills and preloads each make the entry they touch the most recently used.
- R7: A preload installs a page into the least recently used slot, or rewrites the frame of that page if the page is already held. A preload never creates a duplicate, makes the entry the most recent, and leaves the counters unchanged.
- R8: `lookup_count` increases by one for each accepted lookup, and `hit_count` increases by one for each lookup answered by R2.
- R9: After reset, no translation is held, both counters read zero, `rsp_valid` and `pt_rd_en` are low, and `req_ready` is high.
- R10: While a table walk is outstanding, `req_ready` is low. Requests presented during the walk are ignored: they produce no response and are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 8 | Virtual address to translate |
| req_ready | output | 1 | Lookup accepted this cycle if requested |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response came from a held translation |
| rsp_fault | output | 1 | Page-table entry was invalid |
| rsp_paddr | output | 7 | Translated physical address |
| pt_rd_en | output | 1 | Page-table read request |
| pt_rd_addr | output | 7 | Physical address of the entry to read |
| pt_rd_valid | input | 1 | Read data present |
| pt_rd_data | input | 8 | Page-table entry byte |
| pre_valid | input | 1 | Preload request |
| pre_vpn | input | 4 | Page to preload |
| pre_pfn | input | 3 | Frame for the preloaded page |
| hit_count | output | 16 | Running count of hits |
| lookup_count | output | 16 | Running count of accepted lookups |

## Verification
The bench replays a sixteen-reference page stream against an independent recency-list model. A design that evicted the wrong entry would show up there as a hit where a miss is due, or the reverse, and the final hit count would differ. A preload of a page that is already held checks for a rewrite in place: a duplicate entry would hold two frames for one page and push out a live translation. A page with an invalid entry is looked up twice, and a design that installed faulting pages would answer the second lookup as a hit. The bench also presents a second request during a walk and sets junk in bits 6:3 of an entry. It catches a block that accepts or counts stray requests, and one that decodes the frame from the wrong bits.

// File: rtl/xlb_pkg.sv
// Package: shared types for the translation buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package xlb_pkg;
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/xlb_lru.sv
// Module: xlb_lru
// Keeps a recency rank per way (0 = most recent, WAYS-1 = least recent)
// and names the least recent way as the victim.
// Assumes: at most one touch per cycle; ranks start as a permutation.
module xlb_lru #(
    parameter int WAYS  = 3,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_way,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rank_q [WAYS];
    logic [WAYS-1:0]  rank_seen;

    for (genvar w = 0; w < WAYS; w++) begin : g_rank
        // Update one way's rank on a touch: the touched way becomes 0, and younger ways age by one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rank_q[w] <= IDX_W'(WAYS - 1 - w);
            end else if (touch_en) begin
                if (touch_way == IDX_W'(w)) begin
                    rank_q[w] <= '0;
                end else if (rank_q[w] < rank_q[touch_way]) begin
                    rank_q[w] <= rank_q[w] + 1'b1;
                end
            end
        end
    end

    // Select the way holding the oldest rank.
    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rank_q[w] == IDX_W'(WAYS - 1)) victim = IDX_W'(w);
        end
    end

    // Record which rank values are present, for the permutation check.
    always_comb begin
        rank_seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (int'(rank_q[w]) < WAYS) rank_seen[rank_q[w]] = 1'b1;
        end
    end

    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        rank_seen == {WAYS{1'b1}}); // R6
    AST_VICTIM_NOT_RECENT: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> victim != $past(touch_way)); // R6
endmodule

// File: rtl/xlb_ways.sv
// Module: xlb_ways
// Fully associative store of page-to-frame pairs with one search key
// and one write port.
// Assumes: the caller never writes a page that another way already holds.
module xlb_ways #(
    parameter int WAYS  = 3,
    parameter int VPN_W = 4,
    parameter int PFN_W = 3,
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] key_vpn,
    output logic             found,
    output logic [IDX_W-1:0] found_way,
    output logic [PFN_W-1:0] found_pfn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_way,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn
);
    logic [WAYS-1:0]  vld_q;
    logic [VPN_W-1:0] vpn_q [WAYS];
    logic [PFN_W-1:0] pfn_q [WAYS];
    logic [WAYS-1:0]  match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // Hold one translation; cleared by reset, written by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[w] <= 1'b0;
                vpn_q[w] <= '0;
                pfn_q[w] <= '0;
            end else if (wr_en && wr_way == IDX_W'(w)) begin
                vld_q[w] <= 1'b1;
                vpn_q[w] <= wr_vpn;
                pfn_q[w] <= wr_pfn;
            end
        end
        assign match[w] = vld_q[w] && (vpn_q[w] == key_vpn);
    end

    // Encode the matching way and its frame.
    always_comb begin
        found     = |match;
        found_way = '0;
        found_pfn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                found_way = IDX_W'(w);
                found_pfn = pfn_q[w];
            end
        end
    end

    AST_NO_DUPLICATE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R7
    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_way)]); // R6
endmodule

// File: rtl/xlb_walker.sv
// Module: xlb_walker
// One-level page-table walk: issues one read of the entry for a page,
// waits for its data, then reports either a fill or a fault.
// Assumes: pt_rd_valid arrives once for each read, at least one cycle later.
module xlb_walker
    import xlb_pkg::*;
#(
    parameter int VPN_W    = 4,
    parameter int PFN_W    = 3,
    parameter int PA_W     = 7,
    parameter int PTE_W    = 8,
    parameter int PT_FRAME = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    output logic             pt_rd_en,
    output logic [PA_W-1:0]  pt_rd_addr,
    input  logic             pt_rd_valid,
    input  logic [PTE_W-1:0] pt_rd_data,
    output logic             busy,
    output logic             done,
    output logic             fill_en,
    output logic             fault,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn
);
    localparam int FRAME_W = PA_W - VPN_W;

    walk_state_e state_q;
    logic [VPN_W-1:0] vpn_q;

    // Step the walk: idle, issue one read, wait for its data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
            vpn_q   <= '0;
        end else begin
            case (state_q)
                WK_IDLE:  if (start) begin
                              state_q <= WK_ISSUE;
                              vpn_q   <= start_vpn;
                          end
                WK_ISSUE: state_q <= WK_WAIT;
                WK_WAIT:  if (pt_rd_valid) state_q <= WK_IDLE;
                default:  state_q <= WK_IDLE;
            endcase
        end
    end

    // Drive the read port and decode the returned entry.
    always_comb begin
        busy       = (state_q != WK_IDLE);
        pt_rd_en   = (state_q == WK_ISSUE);
        pt_rd_addr = {FRAME_W'(PT_FRAME), vpn_q};
        done       = (state_q == WK_WAIT) && pt_rd_valid;
        fill_en    = done && pt_rd_data[PTE_W-1];
        fault      = done && !pt_rd_data[PTE_W-1];
        fill_vpn   = vpn_q;
        fill_pfn   = pt_rd_data[PFN_W-1:0];
    end

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |=> !pt_rd_en); // R3
    AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R10
    AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R4
endmodule

// File: rtl/xlat_buffer.sv
// Module: xlat_buffer (top)
// Three-way LRU translation buffer: hits answer in the accept cycle, and
// misses walk the page table in a fixed frame and refill the LRU way.
// Assumes: preload has priority over lookups and is applied only while
// no walk is outstanding.
module xlat_buffer #(
    parameter int VA_W     = 8,
    parameter int OFF_W    = 4,
    parameter int PA_W     = 7,
    parameter int WAYS     = 3,
    parameter int PTE_W    = 8,
    parameter int PT_FRAME = 7,
    parameter int CNT_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [VA_W-1:0]           req_vaddr,
    output logic                      req_ready,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic                      rsp_fault,
    output logic [PA_W-1:0]           rsp_paddr,
    output logic                      pt_rd_en,
    output logic [PA_W-1:0]           pt_rd_addr,
    input  logic                      pt_rd_valid,
    input  logic [PTE_W-1:0]          pt_rd_data,
    input  logic                      pre_valid,
    input  logic [VA_W-OFF_W-1:0]     pre_vpn,
    input  logic [PA_W-OFF_W-1:0]     pre_pfn,
    output logic [CNT_W-1:0]          hit_count,
    output logic [CNT_W-1:0]          lookup_count
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic             walk_busy, walk_done, walk_fill, walk_fault;
    logic [VPN_W-1:0] walk_vpn;
    logic [PFN_W-1:0] walk_pfn;
    logic [VPN_W-1:0] key_vpn;
    logic             found;
    logic [IDX_W-1:0] found_way, victim, wr_way, touch_way;
    logic [PFN_W-1:0] found_pfn, wr_pfn;
    logic [VPN_W-1:0] wr_vpn;
    logic             wr_en, accept, hit_now, miss_now, pre_apply;
    logic [OFF_W-1:0] off_q;

    // Arbitrate between preload, lookup and refill.
    always_comb begin
        pre_apply = pre_valid && !walk_busy;
        req_ready = !walk_busy && !pre_valid;
        accept    = req_valid && req_ready;
        key_vpn   = pre_valid ? pre_vpn : req_vaddr[VA_W-1:OFF_W];
        hit_now   = accept && found;
        miss_now  = accept && !found;
        wr_en     = pre_apply || walk_fill;
        wr_way    = (pre_apply && found) ? found_way : victim;
        wr_vpn    = pre_apply ? pre_vpn : walk_vpn;
        wr_pfn    = pre_apply ? pre_pfn : walk_pfn;
        touch_way = hit_now ? found_way : wr_way;
    end

    // Form the response from a hit or from a finished walk.
    always_comb begin
        rsp_valid = hit_now || walk_done;
        rsp_hit   = hit_now;
        rsp_fault = walk_fault;
        if (hit_now)        rsp_paddr = {found_pfn, req_vaddr[OFF_W-1:0]};
        else if (walk_fill) rsp_paddr = {walk_pfn, off_q};
        else                rsp_paddr = '0;
    end

    // Keep the page offset of a missing lookup until its walk returns.
    always_ff @(posedge clk) begin
        if (!rst_n)        off_q <= '0;
        else if (miss_now) off_q <= req_vaddr[OFF_W-1:0];
    end

    // Count accepted lookups and hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count    <= '0;
            lookup_count <= '0;
        end else begin
            if (accept)  lookup_count <= lookup_count + 1'b1;
            if (hit_now) hit_count    <= hit_count + 1'b1;
        end
    end

    xlb_ways #(.WAYS(WAYS), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_ways (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_vpn   (key_vpn),
        .found     (found),
        .found_way (found_way),
        .found_pfn (found_pfn),
        .wr_en     (wr_en),
        .wr_way    (wr_way),
        .wr_vpn    (wr_vpn),
        .wr_pfn    (wr_pfn)
    );

    xlb_lru #(.WAYS(WAYS)) i_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (hit_now || wr_en),
        .touch_way (touch_way),
        .victim    (victim)
    );

    xlb_walker #(.VPN_W(VPN_W), .PFN_W(PFN_W), .PA_W(PA_W), .PTE_W(PTE_W),
                 .PT_FRAME(PT_FRAME)) i_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (miss_now),
        .start_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .pt_rd_en    (pt_rd_en),
        .pt_rd_addr  (pt_rd_addr),
        .pt_rd_valid (pt_rd_valid),
        .pt_rd_data  (pt_rd_data),
        .busy        (walk_busy),
        .done        (walk_done),
        .fill_en     (walk_fill),
        .fault       (walk_fault),
        .fill_vpn    (walk_vpn),
        .fill_pfn    (walk_pfn)
    );

    AST_HIT_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_fault)); // R5
    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !pt_rd_en); // R2
    AST_READY_LOW_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |-> !req_ready); // R10
    AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= lookup_count); // R8
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> rsp_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]); // R1
endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vaddr = '0;
    logic       req_ready, rsp_valid, rsp_hit, rsp_fault;
    logic [6:0] rsp_paddr, pt_rd_addr;
    logic       pt_rd_en;
    logic       pt_rd_valid = 1'b0;
    logic [7:0] pt_rd_data = '0;
    logic       pre_valid = 1'b0;
    logic [3:0] pre_vpn = '0;
    logic [2:0] pre_pfn = '0;
    logic [15:0] hit_count, lookup_count;

    typedef struct { bit hit; bit fault; logic [6:0] paddr; string tag; } sb_item_t;
    sb_item_t sb[$];

    int n_checks = 0, n_err = 0;
    int rec[$];                 // model recency list, front = most recent page
    logic [2:0] mpfn [16];      // model frame per held page
    logic [7:0] ptmem [16];     // page-table bytes at 0x70 + page
    int exp_hits = 0, exp_lookups = 0;
    int rd_count = 0, lat = 0;
    logic [6:0] rd_addr_q = '0;

    always #5 clk = ~clk;

    xlat_buffer i_xlat_buffer (.*);

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Page-table memory: answers each read two cycles after it is seen.
    always @(posedge clk) begin
        if (!rst_n) begin
            pt_rd_valid <= 1'b0;
            lat <= 0;
        end else begin
            pt_rd_valid <= 1'b0;
            if (pt_rd_en) begin
                rd_addr_q <= pt_rd_addr;
                rd_count  <= rd_count + 1;
                lat <= 2;
            end else if (lat == 1) begin
                pt_rd_valid <= 1'b1;
                pt_rd_data  <= (rd_addr_q[6:4] == 3'd7) ? ptmem[rd_addr_q[3:0]] : 8'h00;
                lat <= 0;
            end else if (lat > 1) begin
                lat <= lat - 1;
            end
        end
    end

    // Monitor: pop and compare each response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10", "unexpected response", 1, 0);
            end else begin
                sb_item_t e;
                e = sb.pop_front();
                chk(rsp_hit == e.hit, e.tag, "hit flag (R2)", rsp_hit, e.hit);
                chk(rsp_fault == e.fault, e.tag, "fault flag (R5)", rsp_fault, e.fault);
                if (!e.fault)
                    chk(rsp_paddr == e.paddr, e.tag, "paddr (R1 R4)", rsp_paddr, e.paddr);
            end
        end
    end

    function automatic int find_page(int vpn);
        for (int i = 0; i < rec.size(); i++) if (rec[i] == vpn) return i;
        return -1;
    endfunction

    // Predict the response to a lookup and update the model.
    function automatic sb_item_t predict(logic [7:0] va, output bit was_hit);
        sb_item_t e;
        int vpn = int'(va[7:4]);
        int pos = find_page(vpn);
        exp_lookups++;
        e.fault = 1'b0;
        if (pos >= 0) begin
            was_hit = 1'b1; e.hit = 1'b1; e.tag = "R2";
            e.paddr = {mpfn[vpn], va[3:0]};
            rec.delete(pos); rec.push_front(vpn); exp_hits++;
        end else begin
            was_hit = 1'b0; e.hit = 1'b0;
            if (ptmem[vpn][7]) begin
                e.tag = "R4 R6"; e.paddr = {ptmem[vpn][2:0], va[3:0]};
                mpfn[vpn] = ptmem[vpn][2:0];
                rec.push_front(vpn);
                if (rec.size() > 3) void'(rec.pop_back());
            end else begin
                e.tag = "R5"; e.fault = 1'b1; e.paddr = '0;
            end
        end
        return e;
    endfunction

    task automatic check_reads(bit was_hit, int rc0, logic [3:0] vpn);
        chk(rd_count - rc0 == (was_hit ? 0 : 1), "R3", "table reads", rd_count - rc0, was_hit ? 0 : 1);
        if (!was_hit) chk(rd_addr_q == {3'b111, vpn}, "R3", "table address", rd_addr_q, {3'b111, vpn});
    endtask

    task automatic lookup(logic [7:0] va);
        bit was_hit;
        int rc0 = rd_count;
        sb_item_t e = predict(va, was_hit);
        sb.push_back(e);
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk); #1;
        if (was_hit) chk(sb.size() == 0, "R2", "answered in accept cycle", sb.size(), 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        #1;
        check_reads(was_hit, rc0, va[7:4]);
    endtask

    task automatic preload(logic [3:0] vpn, logic [2:0] pfn);
        int pos = find_page(int'(vpn));
        if (pos >= 0) rec.delete(pos);
        rec.push_front(int'(vpn));
        if (rec.size() > 3) void'(rec.pop_back());
        mpfn[vpn] = pfn;
        @(posedge clk); #1;
        pre_valid = 1'b1; pre_vpn = vpn; pre_pfn = pfn;
        @(posedge clk); #1;
        pre_valid = 1'b0;
    endtask

    // A miss followed by a stray request while the walk is outstanding.
    task automatic busy_probe(logic [7:0] va_miss, logic [7:0] va_stray);
        bit was_hit;
        int rc0 = rd_count;
        sb_item_t e = predict(va_miss, was_hit);
        sb.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b1; req_vaddr = va_miss;
        @(posedge clk); #1;
        req_vaddr = va_stray;
        @(negedge clk);
        chk(req_ready == 1'b0, "R10", "ready during walk", req_ready, 0);
        repeat (2) @(posedge clk);
        #1 req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        #1;
        check_reads(was_hit, rc0, va_miss[7:4]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin ptmem[i] = 8'h00; mpfn[i] = '0; end
        ptmem[0] = 8'h85;  ptmem[13] = 8'h81; ptmem[5] = 8'h82; ptmem[2] = 8'h83;
        ptmem[14] = 8'hF8; ptmem[6] = 8'h84;  ptmem[15] = 8'hB6; ptmem[4] = 8'h7F;
        ptmem[3] = 8'h83;  ptmem[10] = 8'h8C;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
        chk(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);
        chk(pt_rd_en == 1'b0, "R9", "pt_rd_en after reset", pt_rd_en, 0);
        chk(lookup_count == 0 && hit_count == 0, "R9", "counters after reset", lookup_count, 0);
        lookup(8'h03);                       // empty buffer: must miss (R9)
        preload(4'd0, 3'd5); preload(4'd2, 3'd3); preload(4'd13, 3'd1);
        @(negedge clk);
        chk(lookup_count == 1, "R7", "lookups after preload", lookup_count, 1);
        chk(hit_count == 0, "R7", "hits after preload", hit_count, 0);
        begin
            int refs[16] = '{0, 13, 5, 2, 14, 14, 13, 6, 6, 13, 15, 14, 15, 13, 4, 3};
            for (int i = 0; i < 16; i++) lookup({refs[i][3:0], 4'(i)});   // R6 stream
        end
        preload(4'd13, 3'd2);               // rewrite held page (R7)
        lookup(8'hD9);
        busy_probe(8'hA5, 8'hD1);           // R10
        lookup(8'h4E); lookup(8'h41);       // repeated fault (R5)
        @(negedge clk);
        chk(lookup_count == 16'(exp_lookups), "R8", "lookup_count", lookup_count, exp_lookups);
        chk(hit_count == 16'(exp_hits), "R8", "hit_count", hit_count, exp_hits);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule